// File: doc/BRIEF.md
# Bit-serial transversal FIR filter

This block computes a direct-form FIR convolution y(n) = h(0)x(n) + h(1)x(n-1) + ... + h(N-1)x(n-N+1) in bit-serial arithmetic. Every data path inside it is one bit wide. Each input sample arrives as one bit per clock, least significant bit first. A strobe marks the first bit of every word. The filtered result leaves the block in the same form, with its own start strobe. The tap coefficients are fixed two's-complement parameters.

The block is built from three kinds of element. One-word shift registers form the tapped delay line. A serial-parallel multiplier at each tap combines the serial stream with its parallel coefficient. A chain of carry-save serial adders sums the tap products. The word period is set by the 16-bit output width. An 8-bit input sample fills the first eight clocks of a 16-clock frame, and the block sign-extends it internally across the remaining eight clocks.

Top module: `bitser_fir`

## Requirements
- R1: While reset is held, and after reset until the first input word strobe, `serOut` and `outStart` are 0. Samples that come before the first word after reset count as zero in the convolution.
- R2: An input word is 8-bit two's complement sent LSB first, one bit per clock. `serStart` is high in the clock that carries bit 0. Words are contiguous, so `serStart` recurs exactly every 16 clocks.
- R3: The `serIn` values in frame positions 8 to 15 have no effect on the output. The sample is sign-extended from its bit 7.
- R4: Output word n is y(n) = sum over k of h(k)*x(n-k), truncated to its low 16 bits. It is sent as two's complement on `serOut`, LSB first, in 16 consecutive clocks.
- R5: `outStart` is high for one clock per word. It rises two clocks after the clock in which `serStart` was sampled, and it marks the output LSB.
- R6: A sum outside the signed 16-bit range wraps modulo 2^16 and does not saturate.
- R7: A unit impulse (1 followed by zeros) produces the output words h(0), h(1), ..., h(N-1) in that order, then zeros.
- R8: A run of all-ones input words (value -1) produces the negated running sums of the coefficients.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| serIn | input | 1 | Serial sample bit, LSB first |
| serStart | input | 1 | High with bit 0 of each input word |
| serOut | output | 1 | Serial result bit, LSB first |
| outStart | output | 1 | High with bit 0 of each result word |

## Verification
The bench sweeps all 256 input values with random bits in the unused frame positions. A design that fails to sign-extend, or that lets those bits through, would corrupt the upper result bits of every negative or noisy sample. An impulse exposes swapped or misaligned taps, because a tap delay that is off by one clock shifts a coefficient by one binary weight. An alternating run of the largest and smallest samples pushes the sum past 16 bits, so a saturating or carry-leaking adder shows up immediately. The output strobe is checked in every clock, which catches any change in the two-clock pipeline latency.

// File: rtl/bitser_fir_pkg.sv
package bitser_fir_pkg;

  // Per-clock strobes that the framing control hands to the datapath.
  typedef struct packed {
    logic active;     // a word has been seen since reset
    logic wordStart;  // current bit is bit 0 of a word
    logic extend;     // current bit lies past the sample's sign bit
    logic grabSign;   // current bit is the sample's sign bit
  } fir_ctl_t;

endpackage

// File: rtl/bitser_fir_ctrl.sv
module bitser_fir_ctrl
  import bitser_fir_pkg::*;
#(
  parameter int DW = 8,
  parameter int OW = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     serStart,
  output fir_ctl_t ctl
);
  localparam int CNTW = $clog2(OW);
  localparam logic [CNTW-1:0] LAST_POS = CNTW'(OW - 1);
  localparam logic [CNTW-1:0] SIGN_POS = CNTW'(DW - 1);

  logic [CNTW-1:0] bitPos;
  logic [CNTW-1:0] curPos;
  logic            seenWord;

  always_comb begin
    if (serStart || bitPos == LAST_POS) curPos = '0;
    else                                curPos = bitPos + 1'b1;
    ctl.active    = seenWord || serStart;
    ctl.wordStart = serStart;
    ctl.extend    = ctl.active && (curPos > SIGN_POS);
    ctl.grabSign  = ctl.active && (curPos == SIGN_POS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitPos   <= LAST_POS;
      seenWord <= 1'b0;
    end else begin
      bitPos   <= curPos;
      seenWord <= seenWord || serStart;
    end
  end

  // R2
  framing_chk: assert property (@(posedge clk) disable iff (rst)
    (seenWord && bitPos == LAST_POS) |-> serStart)
    else $error("input words are not contiguous");

endmodule

// File: rtl/bitser_fir_delay.sv
module bitser_fir_delay #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic dIn,
  output logic dOut
);
  logic [LEN-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) shiftReg <= '0;
    else     shiftReg <= {shiftReg[LEN-2:0], dIn};
  end

  assign dOut = shiftReg[LEN-1];

endmodule

// File: rtl/bitser_fir_spmul.sv
module bitser_fir_spmul #(
  parameter int              CW   = 8,
  parameter logic [CW-1:0]   COEF = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic wordStart,
  input  logic bitIn,
  output logic prodBit
);
  localparam int AW = CW + 2;
  localparam logic signed [AW-1:0] COEF_EXT = {{2{COEF[CW-1]}}, COEF};
  localparam logic signed [AW-1:0] COEF_MAG = COEF[CW-1] ? -COEF_EXT : COEF_EXT;
  localparam logic signed [AW-1:0] COEF_NEG = -COEF_MAG;

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] partSum;

  always_comb begin
    partSum = (wordStart ? '0 : acc) + (bitIn ? COEF_EXT : '0);
    prodBit = partSum[0];
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= partSum >>> 1;
  end

  // R4
  acc_range_chk: assert property (@(posedge clk) disable iff (rst)
    (acc >= COEF_NEG) && (acc <= COEF_MAG))
    else $error("multiplier residue out of range");

endmodule

// File: rtl/bitser_fir_seradd.sv
module bitser_fir_seradd (
  input  logic clk,
  input  logic rst,
  input  logic clrCarry,
  input  logic aBit,
  input  logic bBit,
  output logic sumBit
);
  logic carry;
  logic carryIn;

  always_comb begin
    carryIn = clrCarry ? 1'b0 : carry;
    sumBit  = aBit ^ bBit ^ carryIn;
  end

  always_ff @(posedge clk) begin
    if (rst) carry <= 1'b0;
    else     carry <= (aBit & bBit) | (aBit & carryIn) | (bBit & carryIn);
  end

endmodule

// File: rtl/bitser_fir_datapath.sv
module bitser_fir_datapath
  import bitser_fir_pkg::*;
#(
  parameter int                  TAPS  = 4,
  parameter int                  OW    = 16,
  parameter int                  CW    = 8,
  parameter logic [TAPS*CW-1:0]  COEFS = '0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     serIn,
  input  fir_ctl_t ctl,
  output logic     serOut,
  output logic     outStart
);
  logic            signBit;
  logic            extBit;
  logic [TAPS-1:0] tapBit;
  logic [TAPS-1:0] prodComb;
  logic [TAPS-1:0] prodReg;
  logic [TAPS-1:0] partial;
  logic            startD1;

  always_comb begin
    if (!ctl.active)    extBit = 1'b0;
    else if (ctl.extend) extBit = signBit;
    else                extBit = serIn;
  end

  always_ff @(posedge clk) begin
    if (rst)               signBit <= 1'b0;
    else if (ctl.grabSign) signBit <= serIn;
  end

  assign tapBit[0] = extBit;

  genvar k;
  generate
    for (k = 1; k < TAPS; k++) begin : g_delay
      bitser_fir_delay #(.LEN(OW)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .dIn  (tapBit[k-1]),
        .dOut (tapBit[k])
      );
    end

    for (k = 0; k < TAPS; k++) begin : g_mul
      bitser_fir_spmul #(.CW(CW), .COEF(COEFS[k*CW +: CW])) u_mul (
        .clk       (clk),
        .rst       (rst),
        .wordStart (ctl.wordStart),
        .bitIn     (tapBit[k]),
        .prodBit   (prodComb[k])
      );
    end

    assign partial[0] = prodReg[0];
    for (k = 1; k < TAPS; k++) begin : g_add
      bitser_fir_seradd u_add (
        .clk      (clk),
        .rst      (rst),
        .clrCarry (startD1),
        .aBit     (partial[k-1]),
        .bBit     (prodReg[k]),
        .sumBit   (partial[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prodReg  <= '0;
      startD1  <= 1'b0;
      serOut   <= 1'b0;
      outStart <= 1'b0;
    end else begin
      prodReg  <= prodComb;
      startD1  <= ctl.wordStart;
      serOut   <= partial[TAPS-1];
      outStart <= startD1;
    end
  end

  // R3
  sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.extend && $past(ctl.extend)) |-> (extBit == $past(extBit)))
    else $error("extension bits not held at sign");

  // R5
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    outStart |=> !outStart)
    else $error("output strobe longer than one clock");

endmodule

// File: rtl/bitser_fir.sv
module bitser_fir
  import bitser_fir_pkg::*;
#(
  parameter int                 TAPS  = 4,
  parameter int                 DW    = 8,
  parameter int                 OW    = 16,
  parameter int                 CW    = 8,
  parameter logic [TAPS*CW-1:0] COEFS = {8'hB3, 8'h64, 8'h80, 8'h7F}
) (
  input  logic clk,
  input  logic rst,
  input  logic serIn,
  input  logic serStart,
  output logic serOut,
  output logic outStart
);
  fir_ctl_t ctl;

  bitser_fir_ctrl #(.DW(DW), .OW(OW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .serStart (serStart),
    .ctl      (ctl)
  );

  bitser_fir_datapath #(.TAPS(TAPS), .OW(OW), .CW(CW), .COEFS(COEFS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .serIn    (serIn),
    .ctl      (ctl),
    .serOut   (serOut),
    .outStart (outStart)
  );

endmodule

// File: tb/bitser_fir_tb.sv
module bitser_fir_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 4;
  localparam int DW   = 8;
  localparam int OW   = 16;
  localparam int CW   = 8;
  localparam logic [TAPS*CW-1:0] COEFS = {8'hB3, 8'h64, 8'h80, 8'h7F};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serIn = 1'b0;
  logic serStart = 1'b0;
  logic serOut;
  logic outStart;

  int checks = 0;
  int errors = 0;

  int xv [0:299];
  int nw = 0;
  int outN = 0;
  int oIdx = OW;
  logic [OW-1:0] oWord;
  logic [1:0] startPipe = 2'b00;
  bit anyWordOut = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitser_fir #(.TAPS(TAPS), .DW(DW), .OW(OW), .CW(CW), .COEFS(COEFS)) u_dut (
    .clk(clk), .rst(rst), .serIn(serIn), .serStart(serStart),
    .serOut(serOut), .outStart(outStart)
  );

  function automatic int hOf(int k);
    logic signed [CW-1:0] c;
    c = COEFS[k*CW +: CW];
    return int'(c);
  endfunction

  function automatic logic [OW-1:0] expY(int n);
    int acc;
    acc = 0;
    for (int k = 0; k < TAPS; k++)
      if (n - k >= 0) acc += hOf(k) * xv[n-k];
    return acc[OW-1:0];
  endfunction

  function automatic string tagOf(int n);
    if (n < 6)       return "R7";
    else if (n < 14) return "R6";
    else if (n < 270) return "R4 R3 R2";
    else             return "R8";
  endfunction

  task automatic pushW(int v);
    xv[nw] = v;
    nw++;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(bit st, bit din);
    @(negedge clk);
    check(outStart == startPipe[1], "R5 strobe", int'(outStart), int'(startPipe[1]));
    if (outStart) begin
      oIdx = 0;
      anyWordOut = 1'b1;
    end
    if (oIdx < OW) begin
      oWord[oIdx] = serOut;
      oIdx++;
      if (oIdx == OW) begin
        logic [OW-1:0] e;
        e = expY(outN);
        check(oWord == e, tagOf(outN), int'(oWord), int'(e));
        outN++;
      end
    end else if (!anyWordOut) begin
      check(serOut == 1'b0, "R1 idle", int'(serOut), 0);
    end
    serStart = st;
    serIn = din;
    startPipe = {startPipe[0], st};
  endtask

  initial begin
    // impulse, then zeros
    pushW(1); for (int i = 0; i < 5; i++) pushW(0);
    // alternating extremes force wraparound
    for (int i = 0; i < 8; i++) pushW((i % 2 == 0) ? 127 : -128);
    // full sweep of the input range
    for (int v = -128; v < 128; v++) pushW(v);
    // all-ones run
    for (int i = 0; i < 6; i++) pushW(-1);
    pushW(0); pushW(0);

    repeat (4) begin
      @(negedge clk);
      check(serOut == 1'b0 && outStart == 1'b0, "R1 reset", int'({outStart, serOut}), 0);
    end
    rst = 1'b0;
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1);

    for (int f = 0; f < nw; f++) begin
      for (int p = 0; p < OW; p++) begin
        logic [7:0] sv;
        bit b;
        sv = xv[f][7:0];
        b = (p < DW) ? sv[p] : bit'($urandom_range(1, 0));
        step(p == 0, b);
      end
    end
    check(outN == nw - 1, "R5 word count", outN, nw - 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule